// File: doc/BRIEF.md
# Programmable Chip-Select Cycle Sequencer

This block runs one external memory cycle at a time for a region that a separate address decoder has already chosen. When a start request is accepted it captures that region's timing attributes: wait states, relaxed timing, acknowledge source, strobe setup, early strobe negation, read hold and burst inhibit. It then produces chip select, output enable, per-byte write/byte enables and an internal transfer acknowledge, one per data beat. All timing is modelled in whole clocks.

A cycle starts in the clock after the edge that accepts the start request. The acknowledge marks the last clock of each beat. Read bursts step through an aligned group of four words and stop at the group's end. A read from a bank with the read-hold option set can force one idle clock before the next cycle.

Top module: `csSeqTop`

## Requirements
- R1: With `relaxed`=0 and `extAckMode`=0, a single access lasts 2 + `waitScy` clocks. `tAck` is high in its last clock only and `busy` is high for exactly those clocks.
- R2: With `relaxed`=1 and internal acknowledge, the wait count is 2·`waitScy`. One clock is added when `csSetup` is nonzero, and another for a write with `csEarlyNeg`=1. A write with both therefore takes 4 + 2·`waitScy` clocks.
- R3: With `relaxed`=1 and `csSetup` nonzero, chip select, output enable and enables stay low in the first clock of the access. For a relaxed write with `csEarlyNeg`=1 under internal acknowledge, the enables are low in the final clock. Chip select is also low in that clock, but only when `csSetup` is nonzero. In every other case the strobes stay high through the final clock.
- R4: With `extAckMode`=1, a beat ends only in a clock where `extAck` is high, and never before clock 2 of the access (clock 3 when `relaxed`=1). No early strobe negation applies in this mode.
- R5: With internal acknowledge, an `extAck` pulse in a clock that still has at least two clocks to run ends the beat in that clock. A pulse arriving later has no effect on length or strobes.
- R6: A burst runs when `burstReq`=1, the access is a read and `burstInhibit`=0. It gives 4 − `wordOffset` beats, where `wordOffset` is the word index within an aligned four-word group, and it never wraps. A write or an inhibited request gives one beat.
- R7: Burst beats after the first last 1 + `waitBscy` clocks (1 + 2·`waitBscy` when relaxed), or one clock per `extAck` in external mode. Chip select stays high between beats.
- R8: After a read with `readHold`=1, one idle clock (busy high, strobes low) precedes the next access if that access is a write or targets a different `region` and is requested in the first idle clock. A read to the same region, or a request made later, gets no idle clock.
- R9: `weOut[i]` follows `laneMask[i]` while the enable window is open. With `byteMode`=0 the enables are driven on writes only. With `byteMode`=1 they are driven on reads as well, with the same timing.
- R10: `oeOut` is high only on reads, in exactly the clocks where `csOut` is high.
- R11: `start` is accepted only while `busy` is low. Starting and the attributes captured at acceptance are unaffected by `start` or attribute changes during a cycle, and `busy` falls only after the final `tAck`.
- R12: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a cycle; captured while idle |
| isWrite | input | 1 | 1 = write, 0 = read |
| burstReq | input | 1 | Request a read burst |
| wordOffset | input | 2 | Word index inside the aligned four-word group |
| region | input | 2 | Index of the selected region |
| waitScy | input | 4 | Wait states of a single access / first beat |
| waitBscy | input | 2 | Wait states of later burst beats |
| relaxed | input | 1 | Relaxed strobe timing |
| extAckMode | input | 1 | Beats end only on external acknowledge |
| csSetup | input | 2 | Strobe setup code; nonzero adds a setup clock when relaxed |
| csEarlyNeg | input | 1 | Early strobe negation on relaxed writes |
| readHold | input | 1 | Idle clock after reads (bus turnaround) |
| burstInhibit | input | 1 | Forbid bursts in this region |
| byteMode | input | 1 | Enables act as byte enables on reads too |
| laneMask | input | 4 | Byte lanes of the transfer |
| extAck | input | 1 | External transfer acknowledge |
| csOut | output | 1 | Chip select, active high |
| oeOut | output | 1 | Output enable, active high |
| weOut | output | 4 | Write/byte enables, active high |
| tAck | output | 1 | Internal transfer acknowledge, one per beat |
| busy | output | 1 | Cycle or idle clock in progress |

## Verification
The hardest situation to reach is the read-hold idle clock. It depends on the previous cycle's kind, bank and option, and it only counts when the next request arrives in the very first idle clock. The stimulus issues each access in the clock where `busy` drops, and chains accesses so that their order, regions and idle delays are controlled. Early-acknowledge timing is reached by sweeping the pulse clock across the whole access. This covers the clocks where it still counts and the ones where it must be ignored.

// File: rtl/csSeqPkg.sv
package csSeqPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_RUN
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch attributes of the accepted request
    logic loadFirst;  // load first-beat count and beat count
    logic loadNext;   // load a later burst beat
    logic tick;       // count one clock of the current beat
    logic run;        // access clocks (strobes allowed)
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic beatEnd;    // current clock closes a beat
    logic moreBeats;  // burst beats remain after this one
    logic holdRead;   // finished access was a read with read hold set
  } seqStatus_t;

endpackage

// File: rtl/csSeqCtrl.sv
module csSeqCtrl
  import csSeqPkg::*;
#(
  parameter int REGION_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                isWrite,
  input  logic [REGION_W-1:0] region,
  input  seqStatus_t          seqStat,
  output seqStrobe_t          seqStrb,
  output logic                busy
);

  seqState_t            state, stateNext;
  logic                 guard;
  logic [REGION_W-1:0]  guardRegion, curRegion;
  logic                 gapNeed, lastEnd;

  assign gapNeed = guard && (isWrite || (region != guardRegion));
  assign lastEnd = (state == ST_RUN) && seqStat.beatEnd && !seqStat.moreBeats;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    seqStrb   = '0;
    stateNext = state;
    seqStrb.run = (state == ST_RUN);
    case (state)
      ST_IDLE: if (start) begin
        seqStrb.capture   = 1'b1;
        seqStrb.loadFirst = !gapNeed;
        stateNext         = gapNeed ? ST_GAP : ST_RUN;
      end
      ST_GAP: begin
        seqStrb.loadFirst = 1'b1;
        stateNext         = ST_RUN;
      end
      ST_RUN: begin
        if (seqStat.beatEnd) begin
          seqStrb.loadNext = seqStat.moreBeats;
          if (!seqStat.moreBeats) stateNext = ST_IDLE;
        end else begin
          seqStrb.tick = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      guard       <= 1'b0;
      guardRegion <= '0;
      curRegion   <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE) guard <= 1'b0;
      if (seqStrb.capture) curRegion <= region;
      if (lastEnd) begin
        guard       <= seqStat.holdRead;
        guardRegion <= curRegion;
      end
    end
  end

endmodule

// File: rtl/csSeqDatapath.sv
module csSeqDatapath
  import csSeqPkg::*;
#(
  parameter int SCY_W     = 4,
  parameter int BSCY_W    = 2,
  parameter int LANES     = 4,
  parameter int BURST_LEN = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqStrobe_t                    seqStrb,
  input  logic                          isWrite,
  input  logic                          burstReq,
  input  logic [$clog2(BURST_LEN)-1:0]  wordOffset,
  input  logic [SCY_W-1:0]              waitScy,
  input  logic [BSCY_W-1:0]             waitBscy,
  input  logic                          relaxed,
  input  logic                          extAckMode,
  input  logic [1:0]                    csSetup,
  input  logic                          csEarlyNeg,
  input  logic                          readHold,
  input  logic                          burstInhibit,
  input  logic                          byteMode,
  input  logic [LANES-1:0]              laneMask,
  input  logic                          extAck,
  output seqStatus_t                    seqStat,
  output logic                          csOut,
  output logic                          oeOut,
  output logic [LANES-1:0]              weOut,
  output logic                          tAck
);

  localparam int OFF_W   = $clog2(BURST_LEN);
  localparam int MAX_LEN = 4 + 2 * ((1 << SCY_W) - 1);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  // attributes held for the running access
  logic              hW, hTr, hSeta, hAcsNz, hCsnt, hEhtr, hByte, hBurst;
  logic [SCY_W-1:0]  hScy;
  logic [BSCY_W-1:0] hBscy;
  logic [OFF_W-1:0]  hOff;
  logic [LANES-1:0]  hLanes;

  // attributes in force this clock (raw on capture, held otherwise)
  logic              nW, nTr, nSeta, nAcsNz, nCsnt, nBurst;
  logic [SCY_W-1:0]  nScy;
  logic [OFF_W-1:0]  nOff;

  logic [CNT_W-1:0]  cnt, scyExt, waitEff, firstLoad, nextLoad, bscyExt;
  logic [OFF_W-1:0]  beats, beatsLoad;
  logic              setupPh, finalClk, csOn, weWin;

  always_comb begin
    if (seqStrb.capture) begin
      nW = isWrite; nTr = relaxed; nSeta = extAckMode; nAcsNz = (csSetup != 2'b00);
      nCsnt = csEarlyNeg; nScy = waitScy; nOff = wordOffset;
      nBurst = burstReq && !isWrite && !burstInhibit;
    end else begin
      nW = hW; nTr = hTr; nSeta = hSeta; nAcsNz = hAcsNz;
      nCsnt = hCsnt; nScy = hScy; nOff = hOff; nBurst = hBurst;
    end
  end

  assign scyExt  = CNT_W'(nScy);
  assign waitEff = nTr ? (scyExt << 1) : scyExt;
  assign firstLoad = nSeta ? (nTr ? CNT_W'(2) : CNT_W'(1))
                           : CNT_W'(1) + waitEff + CNT_W'(nTr & nAcsNz) + CNT_W'(nTr & nW & nCsnt);
  assign beatsLoad = nBurst ? (OFF_W'(BURST_LEN - 1) - nOff) : '0;
  assign bscyExt   = CNT_W'(hBscy);
  assign nextLoad  = hSeta ? '0 : (hTr ? (bscyExt << 1) : bscyExt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {hW, hTr, hSeta, hAcsNz, hCsnt, hEhtr, hByte, hBurst} <= '0;
      hScy <= '0; hBscy <= '0; hOff <= '0; hLanes <= '0;
      cnt <= '0; beats <= '0; setupPh <= 1'b0;
    end else begin
      if (seqStrb.capture) begin
        hW <= isWrite; hTr <= relaxed; hSeta <= extAckMode;
        hAcsNz <= (csSetup != 2'b00); hCsnt <= csEarlyNeg; hEhtr <= readHold;
        hByte <= byteMode; hBurst <= burstReq && !isWrite && !burstInhibit;
        hScy <= waitScy; hBscy <= waitBscy; hOff <= wordOffset; hLanes <= laneMask;
      end
      if (seqStrb.loadFirst) begin
        cnt     <= firstLoad;
        beats   <= beatsLoad;
        setupPh <= nTr & nAcsNz;
      end else if (seqStrb.loadNext) begin
        cnt     <= nextLoad;
        beats   <= beats - OFF_W'(1);
        setupPh <= 1'b0;
      end else if (seqStrb.tick) begin
        cnt     <= (cnt != '0) ? cnt - CNT_W'(1) : '0;
        setupPh <= 1'b0;
      end
    end
  end

  always_comb begin
    if (hSeta) seqStat.beatEnd = seqStrb.run && (cnt == '0) && extAck;
    else       seqStat.beatEnd = seqStrb.run && ((cnt == '0) || (extAck && (cnt >= CNT_W'(2))));
  end
  assign seqStat.moreBeats = (beats != '0);
  assign seqStat.holdRead  = !hW && hEhtr;

  assign finalClk = seqStrb.run && !hSeta && (cnt == '0) && (beats == '0);
  assign csOn  = seqStrb.run && !setupPh && !(finalClk && hTr && hW && hCsnt && hAcsNz);
  assign weWin = seqStrb.run && !setupPh && !(finalClk && hTr && hW && hCsnt);

  assign csOut = csOn;
  assign oeOut = csOn && !hW;
  assign weOut = (weWin && (hW || hByte)) ? hLanes : '0;
  assign tAck  = seqStat.beatEnd;

endmodule

// File: rtl/csSeqTop.sv
module csSeqTop
  import csSeqPkg::*;
#(
  parameter int SCY_W     = 4,
  parameter int BSCY_W    = 2,
  parameter int LANES     = 4,
  parameter int REGION_W  = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic                          isWrite,
  input  logic                          burstReq,
  input  logic [$clog2(BURST_LEN)-1:0]  wordOffset,
  input  logic [REGION_W-1:0]           region,
  input  logic [SCY_W-1:0]              waitScy,
  input  logic [BSCY_W-1:0]             waitBscy,
  input  logic                          relaxed,
  input  logic                          extAckMode,
  input  logic [1:0]                    csSetup,
  input  logic                          csEarlyNeg,
  input  logic                          readHold,
  input  logic                          burstInhibit,
  input  logic                          byteMode,
  input  logic [LANES-1:0]              laneMask,
  input  logic                          extAck,
  output logic                          csOut,
  output logic                          oeOut,
  output logic [LANES-1:0]              weOut,
  output logic                          tAck,
  output logic                          busy
);

  seqStrobe_t seqStrb;
  seqStatus_t seqStat;

  csSeqCtrl #(.REGION_W(REGION_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite), .region(region),
    .seqStat(seqStat), .seqStrb(seqStrb), .busy(busy)
  );

  csSeqDatapath #(
    .SCY_W(SCY_W), .BSCY_W(BSCY_W), .LANES(LANES), .BURST_LEN(BURST_LEN)
  ) u_data (
    .clk(clk), .rstN(rstN), .seqStrb(seqStrb), .isWrite(isWrite), .burstReq(burstReq),
    .wordOffset(wordOffset), .waitScy(waitScy), .waitBscy(waitBscy), .relaxed(relaxed),
    .extAckMode(extAckMode), .csSetup(csSetup), .csEarlyNeg(csEarlyNeg),
    .readHold(readHold), .burstInhibit(burstInhibit), .byteMode(byteMode),
    .laneMask(laneMask), .extAck(extAck), .seqStat(seqStat), .csOut(csOut),
    .oeOut(oeOut), .weOut(weOut), .tAck(tAck)
  );

endmodule

// File: rtl/csSeqCheck.sv
module csSeqCheck #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             csOut,
  input logic             oeOut,
  input logic [LANES-1:0] weOut,
  input logic             tAck
);

  // R11: nothing is driven while idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!csOut && !oeOut && (weOut == '0) && !tAck));

  // R10: output enable never outside chip select
  p_oe_in_cs_r10: assert property (@(posedge clk) disable iff (!rstN)
    oeOut |-> csOut);

  // R1: acknowledge only inside a cycle
  p_ack_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    tAck |-> busy);

  // R11: a cycle begins only from an accepted start
  p_start_begins_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R11: busy is left only through an acknowledge
  p_hold_until_ack_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tAck && csOut) |=> busy);

endmodule

bind csSeqTop csSeqCheck #(.LANES(LANES)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .csOut(csOut),
  .oeOut(oeOut), .weOut(weOut), .tAck(tAck)
);

// File: tb/csSeqTop_test.sv
`timescale 1ns/1ps
module csSeqTop_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, isWrite = 1'b0, burstReq = 1'b0;
  logic [1:0] wordOffset = '0, region = '0, waitBscy = '0, csSetup = '0;
  logic [3:0] waitScy = '0, laneMask = '0;
  logic relaxed = 1'b0, extAckMode = 1'b0, csEarlyNeg = 1'b0, readHold = 1'b0;
  logic burstInhibit = 1'b0, byteMode = 1'b0, extAck = 1'b0;
  logic csOut, oeOut, tAck, busy;
  logic [3:0] weOut;

  always #4 clk = ~clk;  // 125 MHz

  csSeqTop uut (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite), .burstReq(burstReq),
    .wordOffset(wordOffset), .region(region), .waitScy(waitScy), .waitBscy(waitBscy),
    .relaxed(relaxed), .extAckMode(extAckMode), .csSetup(csSetup), .csEarlyNeg(csEarlyNeg),
    .readHold(readHold), .burstInhibit(burstInhibit), .byteMode(byteMode),
    .laneMask(laneMask), .extAck(extAck), .csOut(csOut), .oeOut(oeOut),
    .weOut(weOut), .tAck(tAck), .busy(busy)
  );

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // stimulus settings of the next access
  int tW, tTr, tAcs, tCsnt, tScy, tBscy, tSeta, tEhtr, tBi, tBurst, tOff, tReg, tByte;
  int tAckAt, tPoke, tPreIdle;
  logic [3:0] tLanes;
  // bench model of the read-hold guard
  bit guardExp = 0;
  int prevReg = 0;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic defaults();
    tW = 0; tTr = 0; tAcs = 0; tCsnt = 0; tScy = 0; tBscy = 0; tSeta = 0; tEhtr = 0;
    tBi = 1; tBurst = 0; tOff = 0; tReg = 0; tByte = 0; tLanes = 4'hF;
    tAckAt = 0; tPoke = 0; tPreIdle = 0;
  endtask

  task automatic doRun(input string req);
    int g, d, w, wc, l1, e1, nb, b, tot, csLast, weLast, minL, k;
    bit negOk, weBad;
    logic [63:0] expAck, expCs, expWe, gotAck, gotCs, gotOe, gotWe;
    if (tPreIdle > 0) begin
      repeat (tPreIdle) @(posedge clk);
      @(negedge clk); #1;
      guardExp = 0;
    end
    g  = (guardExp && (tW != 0 || tReg != prevReg)) ? 1 : 0;
    d  = (tTr != 0 && tAcs != 0) ? 1 : 0;
    w  = (tTr != 0) ? 2 * tScy : tScy;
    wc = (tTr != 0 && tW != 0 && tCsnt != 0) ? 1 : 0;
    if (tSeta != 0) begin
      minL = (tTr != 0) ? 3 : 2;
      e1 = (tAckAt > minL) ? tAckAt : minL;
      b = 1; negOk = 0;
    end else begin
      l1 = 2 + w + d + wc;
      if (tAckAt >= 1 && l1 - tAckAt >= 2) begin e1 = tAckAt; negOk = 0; end
      else begin e1 = l1; negOk = 1; end
      b = 1 + ((tTr != 0) ? 2 * tBscy : tBscy);
    end
    nb  = (tBurst != 0 && tW == 0 && tBi == 0) ? 4 - tOff : 1;
    tot = e1 + (nb - 1) * b;
    csLast = tot - ((negOk && wc == 1 && d == 1) ? 1 : 0);
    weLast = tot - ((negOk && wc == 1) ? 1 : 0);
    expAck = '0; expCs = '0; expWe = '0;
    for (int i = 0; i < nb; i++) expAck[g + e1 + i * b] = 1'b1;
    for (int i = 1 + d; i <= csLast; i++) expCs[g + i] = 1'b1;
    if (tW != 0 || tByte != 0)
      for (int i = 1 + d; i <= weLast; i++) expWe[g + i] = 1'b1;

    isWrite = tW[0]; relaxed = tTr[0]; csSetup = 2'(tAcs); csEarlyNeg = tCsnt[0];
    waitScy = 4'(tScy); waitBscy = 2'(tBscy); extAckMode = tSeta[0]; readHold = tEhtr[0];
    burstInhibit = tBi[0]; burstReq = tBurst[0]; wordOffset = 2'(tOff); region = 2'(tReg);
    byteMode = tByte[0]; laneMask = tLanes;
    start = 1'b1;
    gotAck = '0; gotCs = '0; gotOe = '0; gotWe = '0; weBad = 0;
    k = 1;
    while (k < 63) begin
      @(negedge clk);
      start = (tPoke != 0 && k == 2);
      if (tPoke != 0 && k == 2) begin isWrite = ~isWrite; relaxed = ~relaxed; waitScy = 4'd15; end
      if (tPoke != 0 && k == 3) begin isWrite = tW[0]; relaxed = tTr[0]; waitScy = 4'(tScy); end
      if (tSeta != 0) extAck = (tAckAt >= 1 && k - g >= tAckAt);
      else            extAck = (tAckAt >= 1 && k - g == tAckAt);
      #1;
      if (!busy) break;
      gotAck[k] = tAck; gotCs[k] = csOut; gotOe[k] = oeOut;
      gotWe[k] = (weOut != 4'h0);
      if (weOut != 4'h0 && weOut != tLanes) weBad = 1;
      k++;
    end
    extAck = 1'b0; start = 1'b0;
    check({req, " length"}, 64'(k - 1), 64'(g + tot));
    check({req, " ack"}, gotAck, expAck);
    check({req, " cs"}, gotCs, expCs);
    check("R10 oe", gotOe, (tW != 0) ? 64'd0 : expCs);
    check("R9 enables", gotWe, expWe);
    check("R9 lanes", 64'(weBad), 64'd0);
    guardExp = (tW == 0 && tEhtr != 0);
    prevReg = tReg;
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    #1;
    // R12: reset state
    check("R12 reset", {csOut, oeOut, weOut, tAck, busy}, '0);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R12 after release", {csOut, oeOut, weOut, tAck, busy}, '0);

    // R1 normal timing sweep, R2/R3 relaxed timing sweep
    for (int tr = 0; tr < 2; tr++)
      for (int wr = 0; wr < 2; wr++)
        for (int acs = 0; acs < 4; acs++)
          for (int cn = 0; cn < 2; cn++)
            for (int s = 0; s < 16; s++) begin
              defaults();
              tTr = tr; tW = wr; tAcs = acs; tCsnt = cn; tScy = s;
              if (tr == 0) doRun("R1");
              else if (acs != 0 || cn != 0) doRun("R3");
              else doRun("R2");
            end

    // R4 external acknowledge mode
    for (int tr = 0; tr < 2; tr++)
      for (int wr = 0; wr < 2; wr++)
        for (int a = 1; a < 6; a++) begin
          defaults();
          tSeta = 1; tTr = tr; tW = wr; tAckAt = a; tAcs = 3 * wr; tCsnt = 1; tScy = 7;
          doRun("R4");
        end

    // R5 early external acknowledge across every clock of the access
    for (int tr = 0; tr < 2; tr++)
      for (int s = 0; s < 8; s++)
        for (int a = 1; a < 18; a++) begin
          defaults();
          tTr = tr; tScy = s; tAckAt = a; tW = a % 2;
          if (a <= 2 + ((tr != 0) ? 2 * s : s)) doRun("R5");
        end

    // R6/R7 bursts: offsets, beat waits, inhibit, writes
    for (int tr = 0; tr < 2; tr++)
      for (int bi = 0; bi < 2; bi++)
        for (int off = 0; off < 4; off++)
          for (int bs = 0; bs < 4; bs++)
            for (int wr = 0; wr < 2; wr++) begin
              defaults();
              tBurst = 1; tTr = tr; tBi = bi; tOff = off; tBscy = bs; tW = wr;
              tScy = off; tAcs = 2 * tr;
              if (bi == 0 && wr == 0) doRun("R7"); else doRun("R6");
            end
    defaults(); tBurst = 1; tBi = 0; tSeta = 1; tAckAt = 4; tOff = 1;
    doRun("R7");

    // R8 read-hold idle clock
    defaults(); tEhtr = 1; tReg = 0; doRun("R8");
    defaults(); tEhtr = 1; tReg = 0; tScy = 2; doRun("R8");
    defaults(); tReg = 1; doRun("R8");
    defaults(); tEhtr = 1; tReg = 1; doRun("R8");
    defaults(); tW = 1; tReg = 1; tScy = 1; doRun("R8");
    defaults(); tEhtr = 1; tReg = 2; doRun("R8");
    defaults(); tW = 1; tReg = 2; tPreIdle = 1; doRun("R8");
    defaults(); tReg = 3; doRun("R8");
    defaults(); tW = 1; tReg = 3; doRun("R8");
    defaults(); tEhtr = 1; tReg = 1; tBurst = 1; tBi = 0; tOff = 2; doRun("R8");
    defaults(); tEhtr = 1; tReg = 3; tTr = 1; tAcs = 3; doRun("R8");

    // R9 enable modes and lane patterns
    for (int bm = 0; bm < 2; bm++)
      for (int wr = 0; wr < 2; wr++)
        for (int ln = 1; ln < 16; ln += 3) begin
          defaults();
          tByte = bm; tW = wr; tLanes = 4'(ln); tScy = 2; tTr = wr; tCsnt = 1; tAcs = 2;
          doRun("R9");
        end

    // R11 start and attribute changes during a cycle are ignored
    defaults(); tPoke = 1; tW = 1; tScy = 3; doRun("R11");
    repeat (2) @(negedge clk);
    #1;
    check("R11 stays idle", 64'(busy), 64'd0);
    defaults(); tPoke = 1; tScy = 1; tTr = 1; tAcs = 1; doRun("R11");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule